// File: doc/BRIEF.md
# DMA Channel Event Synchronization Unit

This block lets a group of DMA channel threads coordinate with each other through a small set of numbered events. On each clock, every channel may present one command: send an event number, or wait on an event number. A channel that waits on an event nobody has sent is halted until some channel sends it. Every channel already waiting on that event is then released in the same cycle. An event sent while nobody waits stays pending. The first later waiter takes it after a one-cycle halt, and any waiter after that blocks until the next send.

A per-event enable register turns an event into an interrupt source. When an event's bit is set, a send on it raises that event's interrupt line instead of touching the pending flags or any waiting channel. Software drops an interrupt line by writing a one to that bit in the clear register. A separate abort interrupt latches when the abort condition is seen and is removed only by resetting the block.

Top module: `dma_evsync`

## Requirements
- R1: After rst_ni is asserted, all bits of stall_o, irq_o and irq_abort_o are 0, and the enable register reads 0.
- R2: Register address 0 is the enable register: it is read/write, only bits [7:0] are stored, and all higher bits read 0. Address 1 is the clear register and always reads 0. Every other address reads 0 and ignores writes.
- R3: Channel c takes its command from cmd_op_i[2c+1:2c] and its event number from cmd_ev_i[3c+2:3c]. The command codes are 00 idle, 01 send, 10 wait, and 11 reserved. The reserved code is ignored, and so is any command from a channel whose stall_o bit is high.
- R4: A send on event e while enable bit e is 1 sets irq_o[e] on the next clock. It neither releases waiters nor leaves event e pending.
- R5: Writing the clear register with bit e at 1 deasserts irq_o[e] on the next clock. If a send on an enabled event e arrives in the same cycle, the set wins.
- R6: A wait on event e while e is not pending raises that channel's stall_o bit on the next clock. The bit stays high until event e is sent.
- R7: A send on event e while enable bit e is 0 releases every channel already waiting on e. Each released channel's stall_o bit is low on the next clock, and event e is not left pending.
- R8: A send on event e with no waiter leaves e pending. The next wait on e holds that channel's stall_o high for exactly one clock and consumes the event. A later wait on e stalls until the next send.
- R9: A send and a wait on the same event in the same cycle are handled as if the send came first: the waiter gets the one-cycle halt of R8, and nothing is left pending.
- R10: If several channels wait on a pending event in the same cycle, the lowest-numbered one consumes it with a one-cycle halt, and the others stall.
- R11: irq_abort_o is set on the clock after abort_i is high and stays set until rst_ni is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_op_i | input | 2*NUM_CH | Per-channel command code |
| cmd_ev_i | input | EV_W*NUM_CH | Per-channel event number |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | REG_W | Register write data |
| reg_rdata_o | output | REG_W | Register read data (combinational on address) |
| abort_i | input | 1 | Abort condition |
| stall_o | output | NUM_CH | Channel halted when 1 |
| irq_o | output | NUM_EV | Per-event interrupt lines |
| irq_abort_o | output | 1 | Abort interrupt |

## Verification
The assertions check several rules on every cycle:
- A one-cycle halt always returns the channel to running.
- A waiting channel keeps its event number until it is released.
- A release or a grant always clears the pending flag.
- At most one newcomer is granted.
- Enabled sends always land in irq_o, and a clear without a competing set always drops the line.
- The abort interrupt never falls on its own.

Only the bench scenarios can show the ordering behaviour, because it spans several commands. These scenarios cover a send that stays pending for a later waiter, the second waiter blocking, same-cycle send and wait, priority among simultaneous newcomers, and commands ignored from stalled channels or with the reserved code.

// File: rtl/dma_evsync_pkg.sv
`timescale 1ns/1ps
package dma_evsync_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_SEND = 2'b01,
    OP_WAIT = 2'b10,
    OP_RSVD = 2'b11
  } ev_op_e;

  typedef enum logic [1:0] {
    CH_RUN  = 2'b00,
    CH_WAIT = 2'b01,
    CH_HALT = 2'b10
  } ch_state_e;

  localparam int unsigned ADDR_ENABLE = 0;
  localparam int unsigned ADDR_CLEAR  = 1;
endpackage

// File: rtl/evsync_regs.sv
`timescale 1ns/1ps
module evsync_regs
  import dma_evsync_pkg::*;
#(
  parameter int unsigned NUM_EV = 8,
  parameter int unsigned REG_W  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic [NUM_EV-1:0] irq_set_i,
  input  logic              abort_i,
  output logic [NUM_EV-1:0] en_o,
  output logic [NUM_EV-1:0] irq_o,
  output logic              irq_abort_o
);
  logic [NUM_EV-1:0] en_q, irq_q, clr_mask;
  logic              abort_q, wr_en, wr_clr;
  logic              unused_wdata;

  assign wr_en  = reg_we_i && (reg_addr_i == ADDR_W'(ADDR_ENABLE));
  assign wr_clr = reg_we_i && (reg_addr_i == ADDR_W'(ADDR_CLEAR));
  assign clr_mask = wr_clr ? reg_wdata_i[NUM_EV-1:0] : '0;
  assign unused_wdata = ^reg_wdata_i[REG_W-1:NUM_EV];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      irq_q   <= '0;
      abort_q <= 1'b0;
    end else begin
      if (wr_en) en_q <= reg_wdata_i[NUM_EV-1:0];
      // set dominates clear so a fresh send is never lost
      irq_q   <= (irq_q & ~clr_mask) | irq_set_i;
      abort_q <= abort_q | abort_i;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(ADDR_ENABLE)) reg_rdata_o[NUM_EV-1:0] = en_q;
  end

  assign en_o        = en_q;
  assign irq_o       = irq_q;
  assign irq_abort_o = abort_q;

  // R4
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_set_i) |=> ((irq_q & $past(irq_set_i)) == $past(irq_set_i)));
  // R5
  irq_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr && ((reg_wdata_i[NUM_EV-1:0] & irq_set_i) == '0))
      |=> ((irq_q & $past(reg_wdata_i[NUM_EV-1:0])) == '0));
  // R11
  abort_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_abort_o |=> irq_abort_o);
endmodule

// File: rtl/evsync_event.sv
`timescale 1ns/1ps
module evsync_event #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sig_i,      // send with interrupt mode off
  input  logic [NUM_CH-1:0] waiters_i,  // channels already blocked on this event
  input  logic [NUM_CH-1:0] newwait_i,  // channels issuing a wait this cycle
  output logic [NUM_CH-1:0] release_o,
  output logic [NUM_CH-1:0] grant_o
);
  logic pend_q, pend_d, eff;

  // a same-cycle send counts as already pending
  assign eff = pend_q | sig_i;

  always_comb begin
    release_o = '0;
    grant_o   = '0;
    pend_d    = eff;
    if (eff) begin
      if (|waiters_i) begin
        release_o = waiters_i;
        pend_d    = 1'b0;
      end else if (|newwait_i) begin
        grant_o = newwait_i & (~newwait_i + NUM_CH'(1));
        pend_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  // R7
  release_consumes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|release_o) |=> !pend_q);
  // R10
  grant_consumes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|grant_o) |=> !pend_q);
  // R10
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o) && !((|grant_o) && (|release_o)));
endmodule

// File: rtl/evsync_chan.sv
`timescale 1ns/1ps
module evsync_chan
  import dma_evsync_pkg::*;
#(
  parameter int unsigned EV_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wfe_i,
  input  logic [EV_W-1:0] ev_i,
  input  logic            grant_i,
  input  logic            release_i,
  output logic            stall_o,
  output logic            waiting_o,
  output logic [EV_W-1:0] wait_ev_o
);
  ch_state_e       state_q, state_d;
  logic [EV_W-1:0] ev_q, ev_d;

  always_comb begin
    state_d = state_q;
    ev_d    = ev_q;
    unique case (state_q)
      CH_RUN: if (wfe_i) begin
        state_d = grant_i ? CH_HALT : CH_WAIT;
        ev_d    = ev_i;
      end
      CH_WAIT: if (release_i) state_d = CH_RUN;
      CH_HALT: state_d = CH_RUN;
      default: state_d = CH_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CH_RUN;
      ev_q    <= '0;
    end else begin
      state_q <= state_d;
      ev_q    <= ev_d;
    end
  end

  assign stall_o   = (state_q != CH_RUN);
  assign waiting_o = (state_q == CH_WAIT);
  assign wait_ev_o = ev_q;

  // R8
  halt_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CH_HALT) |=> (state_q == CH_RUN));
  // R6
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CH_WAIT && !release_i) |=> (state_q == CH_WAIT && $stable(ev_q)));
endmodule

// File: rtl/dma_evsync.sv
`timescale 1ns/1ps
module dma_evsync
  import dma_evsync_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned NUM_EV = 8,
  parameter int unsigned REG_W  = 32,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned EV_W  = $clog2(NUM_EV)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [2*NUM_CH-1:0]    cmd_op_i,
  input  logic [EV_W*NUM_CH-1:0] cmd_ev_i,
  input  logic                   reg_we_i,
  input  logic [ADDR_W-1:0]      reg_addr_i,
  input  logic [REG_W-1:0]       reg_wdata_i,
  output logic [REG_W-1:0]       reg_rdata_o,
  input  logic                   abort_i,
  output logic [NUM_CH-1:0]      stall_o,
  output logic [NUM_EV-1:0]      irq_o,
  output logic                   irq_abort_o
);
  logic [NUM_CH-1:0][EV_W-1:0]   ev_c, wait_ev;
  logic [NUM_CH-1:0]             is_send, is_wait, waiting, rel_ch, grant_ch, stall;
  logic [NUM_EV-1:0][NUM_CH-1:0] waiters_m, newwait_m, release_m, grant_m;
  logic [NUM_EV-1:0]             sev_any, en, sig, irq_set;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    ev_op_e op;
    assign op         = ev_op_e'(cmd_op_i[2*c +: 2]);
    assign ev_c[c]    = cmd_ev_i[EV_W*c +: EV_W];
    // stalled channels and the reserved code issue nothing
    assign is_send[c] = !stall[c] && (op == OP_SEND);
    assign is_wait[c] = !stall[c] && (op == OP_WAIT);
  end

  always_comb begin
    sev_any   = '0;
    waiters_m = '0;
    newwait_m = '0;
    for (int e = 0; e < NUM_EV; e++) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (is_send[c] && ev_c[c] == EV_W'(e)) sev_any[e] = 1'b1;
        newwait_m[e][c] = is_wait[c] && (ev_c[c] == EV_W'(e));
        waiters_m[e][c] = waiting[c] && (wait_ev[c] == EV_W'(e));
      end
    end
  end

  assign sig     = sev_any & ~en;
  assign irq_set = sev_any & en;

  evsync_regs #(.NUM_EV(NUM_EV), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .irq_set_i(irq_set), .abort_i, .en_o(en), .irq_o, .irq_abort_o
  );

  for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
    evsync_event #(.NUM_CH(NUM_CH)) u_ev (
      .clk_i, .rst_ni,
      .sig_i(sig[e]),
      .waiters_i(waiters_m[e]),
      .newwait_i(newwait_m[e]),
      .release_o(release_m[e]),
      .grant_o(grant_m[e])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign rel_ch[c]   = release_m[wait_ev[c]][c];
    assign grant_ch[c] = grant_m[ev_c[c]][c];

    evsync_chan #(.EV_W(EV_W)) u_ch (
      .clk_i, .rst_ni,
      .wfe_i(is_wait[c]),
      .ev_i(ev_c[c]),
      .grant_i(grant_ch[c]),
      .release_i(rel_ch[c]),
      .stall_o(stall[c]),
      .waiting_o(waiting[c]),
      .wait_ev_o(wait_ev[c])
    );

    // R7
    release_resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rel_ch[c] |=> !stall_o[c]);
  end

  assign stall_o = stall;
endmodule

// File: tb/tb_dma_evsync.sv
`timescale 1ns/1ps
module tb_dma_evsync;
  localparam int NCH = 4;
  localparam int NEV = 8;
  localparam int EVW = 3;
  localparam logic [1:0] SEND = 2'b01, WAIT = 2'b10, RSVD = 2'b11;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [2*NCH-1:0]  op = '0;
  logic [EVW*NCH-1:0] ev = '0;
  logic              we = 1'b0;
  logic [3:0]        addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              abort = 1'b0;
  logic [NCH-1:0]    stall;
  logic [NEV-1:0]    irq;
  logic              irq_abort;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_evsync dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_op_i(op), .cmd_ev_i(ev),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .abort_i(abort), .stall_o(stall), .irq_o(irq), .irq_abort_o(irq_abort)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    op = '0; ev = '0; we = 1'b0; abort = 1'b0;
  endtask

  task automatic cmd(input int c, input logic [1:0] o, input int e);
    op[2*c +: 2] = o;
    ev[EVW*c +: EVW] = EVW'(e);
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    addr = 4'd0; #0.5;
    chk("R1 stall", 32'(stall), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 abort", 32'(irq_abort), 0);
    chk("R1 enable", rdata, 0);
  endtask

  task automatic t_regs();
    wreg(4'd0, 32'hFFFF_FF5A);
    addr = 4'd0; #0.5; chk("R2 enable low bits", rdata, 32'h5A);
    addr = 4'd1; #0.5; chk("R2 clear reads 0", rdata, 0);
    addr = 4'd5; #0.5; chk("R2 other addr", rdata, 0);
    wreg(4'd5, 32'hFF);
    addr = 4'd0; #0.5; chk("R2 write elsewhere ignored", rdata, 32'h5A);
    wreg(4'd0, 32'h0);
    addr = 4'd0; #0.5; chk("R2 enable cleared", rdata, 0);
  endtask

  task automatic t_wait_release();
    cmd(0, WAIT, 2); cmd(1, WAIT, 2); cmd(3, WAIT, 2); tick();
    chk("R6 waiters stall", 32'(stall), 32'b1011);
    cmd(0, SEND, 5); tick();
    chk("R6 still stalled", 32'(stall), 32'b1011);
    cmd(2, SEND, 2); tick();
    chk("R7 all released", 32'(stall), 32'b0000);
    cmd(0, WAIT, 2); tick(); tick();
    chk("R7 nothing left pending", 32'(stall), 32'b0001);
    cmd(1, WAIT, 5); tick(); tick();
    chk("R3 stalled channel send ignored", 32'(stall), 32'b0011);
    cmd(2, SEND, 2); cmd(3, SEND, 5); tick();
    chk("R7 release two events", 32'(stall), 32'b0000);
    cmd(2, RSVD, 4); tick();
    chk("R3 reserved no stall", 32'(stall), 32'b0000);
    cmd(1, WAIT, 4); tick(); tick();
    chk("R3 reserved did not send", 32'(stall), 32'b0010);
    cmd(0, SEND, 4); tick();
    chk("R7 release", 32'(stall), 0);
  endtask

  task automatic t_pending();
    cmd(2, SEND, 6); tick(); tick();
    cmd(3, WAIT, 6); tick();
    chk("R8 one-cycle halt", 32'(stall), 32'b1000);
    tick();
    chk("R8 resumes", 32'(stall), 32'b0000);
    cmd(1, WAIT, 6); tick();
    chk("R8 second waiter stalls", 32'(stall), 32'b0010);
    tick();
    chk("R8 second waiter holds", 32'(stall), 32'b0010);
    cmd(0, SEND, 6); tick();
    chk("R8 next send releases", 32'(stall), 0);
  endtask

  task automatic t_same_cycle();
    cmd(0, SEND, 1); cmd(1, WAIT, 1); tick();
    chk("R9 one-cycle halt", 32'(stall), 32'b0010);
    tick();
    chk("R9 resumes", 32'(stall), 32'b0000);
    cmd(2, WAIT, 1); tick(); tick();
    chk("R9 nothing pending", 32'(stall), 32'b0100);
    cmd(3, SEND, 1); tick();
    chk("R9 release", 32'(stall), 0);
  endtask

  task automatic t_multi();
    cmd(0, SEND, 3); tick();
    cmd(1, WAIT, 3); cmd(2, WAIT, 3); cmd(3, WAIT, 3); tick();
    chk("R10 all stall first", 32'(stall), 32'b1110);
    tick();
    chk("R10 lowest resumes", 32'(stall), 32'b1100);
    tick();
    chk("R10 others hold", 32'(stall), 32'b1100);
    cmd(0, SEND, 3); tick();
    chk("R10 release", 32'(stall), 0);
  endtask

  task automatic t_irq();
    wreg(4'd0, 32'h81);
    cmd(1, WAIT, 7); tick();
    chk("R6 wait ev7", 32'(stall), 32'b0010);
    cmd(0, SEND, 7); tick();
    chk("R4 irq raised", 32'(irq), 32'h80);
    chk("R4 no wake", 32'(stall), 32'b0010);
    tick();
    chk("R4 still waiting", 32'(stall), 32'b0010);
    cmd(2, SEND, 0); addr = 4'd1; wdata = 32'h81; we = 1'b1; tick();
    chk("R5 clear vs set", 32'(irq), 32'h01);
    wreg(4'd1, 32'h01);
    chk("R5 cleared", 32'(irq), 0);
    wreg(4'd0, 32'h0);
    cmd(0, SEND, 7); tick();
    chk("R4 signal mode releases", 32'(stall), 0);
    cmd(2, WAIT, 0); tick(); tick();
    chk("R4 irq send left nothing pending", 32'(stall), 32'b0100);
    cmd(0, SEND, 0); tick();
    chk("R7 release", 32'(stall), 0);
  endtask

  task automatic t_abort();
    abort = 1'b1; tick();
    chk("R11 abort set", 32'(irq_abort), 1);
    tick(); tick(); tick();
    chk("R11 abort held", 32'(irq_abort), 1);
    rst_ni = 1'b0; tick();
    chk("R11 reset clears abort", 32'(irq_abort), 0);
    chk("R1 reset clears stall", 32'(stall), 0);
    rst_ni = 1'b1; tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    tick();
    t_reset();
    t_regs();
    t_wait_release();
    t_pending();
    t_same_cycle();
    t_multi();
    t_irq();
    t_abort();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule